// File: doc/BRIEF.md
# Recirculating Interleaved Test-Pattern Player

This block stores a fixed test pattern on chip and plays it to a 6-bit data converter during test. The store is a bank of 48 shift registers, 104 bits deep (4992 bits). While loading, the bank is wired as one long serial chain and filled one bit per strobed clock from a single serial input. During playback every register rotates its own contents: the bit leaving its far end re-enters at its near end. As a result the pattern repeats with no gap, and the switching activity is identical for any stored data.

The 48 register taps form eight 6-bit lanes. A 3-bit phase counter steps once for each fast-rate enable and picks one lane per step, so every memory shift yields eight consecutive samples. Fast and slow rates are modelled as one clock plus enable strobes: `fast_en` marks a sample slot, and the memory shifts on the slot that wraps the phase from 7 to 0.

Top module: `tpm_pattern_player`

## Requirements
- R1: Synchronous reset (`rst` high) puts the block in load mode with phase 0. `sample_out` then reads 0 until playback is entered.
- R2: In load mode, each clock with `load_en` high shifts `load_bit` into the chain. Register 0 takes the serial bit, and each register's tap feeds the next register. Once 4992 bits are loaded, with bit j (0-based, in load order), register k's tap holds bit (47-k)*104.
- R3: In playback, during memory cycle m (0..103) and phase p, bit b of `sample_out` equals loaded bit (47-(6p+b))*104 + m. Register k drives bit k mod 6 of lane k div 6.
- R4: In playback the phase goes up by one on each `fast_en` clock, wrapping 7 to 0. Lane 0 is sent first in each memory cycle.
- R5: All registers rotate by one position only on a `fast_en` clock at phase 7. The 832-sample sequence repeats with no gap.
- R6: In playback, a clock without `fast_en` leaves `sample_out` unchanged.
- R7: When `mode_play_req` falls during playback, the block keeps playing until the `fast_en` clock at phase 7. That clock still rotates the memory, and then load mode begins.
- R8: A clock in load mode with `mode_play_req` high enters playback at phase 0, with the stored contents kept. The output resumes at the next memory cycle.
- R9: `load_en` has no effect in playback, and `fast_en` has no effect in load mode.
- R10: `sample_out` is 0 throughout load mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all state |
| rst | input | 1 | Synchronous active-high reset |
| mode_play_req | input | 1 | 1 requests playback, 0 requests load |
| load_en | input | 1 | Serial load strobe (load mode only) |
| load_bit | input | 1 | Serial pattern data |
| fast_en | input | 1 | Sample-slot strobe (playback only) |
| sample_out | output | 6 | Interleaved output sample |

## Verification
Two events can land on the same clock: a mode change back to load and the memory rotation at phase 7. The bench drops `mode_play_req` in the middle of a memory cycle and keeps the `fast_en` strobes running. It checks that every remaining lane still matches the pattern, and that the output turns to zero only after the wrapping edge. When playback resumes, the first sample must come from the next memory cycle, which proves the rotation on the mode-change edge took place. Load strobes sent during playback, and fast strobes sent during load, are judged only by the sample sequence that follows them.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
   typedef enum logic {
      TPM_LOAD = 1'b0,
      TPM_PLAY = 1'b1
   } tpm_mode_e;
endpackage

// File: rtl/tpm_phase_ctrl.sv
module tpm_phase_ctrl #(
   parameter int unsigned LANES = 8,
   localparam int unsigned PH_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            mode_play_req,
   input  logic            load_en,
   input  logic            fast_en,
   output logic            play,
   output logic [PH_W-1:0] phase,
   output logic            mem_step,
   output logic            load_step
);
   import tpm_pkg::*;

   localparam logic [PH_W-1:0] LAST = PH_W'(LANES - 1);

   tpm_mode_e  mode_q;
   logic       boundary;

   assign play      = (mode_q == TPM_PLAY);
   assign mem_step  = play && fast_en && (phase == LAST);
   assign load_step = !play && load_en;
   assign boundary  = !play || mem_step;

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= TPM_LOAD;
         phase  <= '0;
      end else begin
         if (boundary)
            mode_q <= mode_play_req ? TPM_PLAY : TPM_LOAD;
         if (!play)
            phase <= '0;
         else if (fast_en)
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
      end
   end
endmodule

// File: rtl/tpm_shift_array.sv
module tpm_shift_array #(
   parameter int unsigned NUM_REG = 48,
   parameter int unsigned REG_LEN = 104
) (
   input  logic               clk,
   input  logic               load_step,
   input  logic               mem_step,
   input  logic               load_bit,
   output logic [NUM_REG-1:0] taps
);
   for (genvar k = 0; k < NUM_REG; k++) begin : g_reg
      logic [REG_LEN-1:0] sr;
      logic               chain_in;
      logic               feed;

      if (k == 0) begin : g_head
         assign chain_in = load_bit;
      end else begin : g_link
         assign chain_in = taps[k-1];
      end

      assign feed    = load_step ? chain_in : sr[0];
      assign taps[k] = sr[0];

      always_ff @(posedge clk) begin
         if (load_step || mem_step)
            sr <= {feed, sr[REG_LEN-1:1]};
      end
   end
endmodule

// File: rtl/tpm_lane_mux.sv
module tpm_lane_mux #(
   parameter int unsigned LANES    = 8,
   parameter int unsigned SAMPLE_W = 6,
   localparam int unsigned PH_W    = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int unsigned TAPS    = LANES * SAMPLE_W
) (
   input  logic [TAPS-1:0]     taps,
   input  logic [PH_W-1:0]     phase,
   input  logic                play,
   output logic [SAMPLE_W-1:0] sample
);
   logic [SAMPLE_W-1:0] lane [LANES];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane[l] = taps[l*SAMPLE_W +: SAMPLE_W];
   end

   always_comb begin
      sample = '0;
      if (play)
         sample = lane[phase];
   end
endmodule

// File: rtl/tpm_pattern_player.sv
module tpm_pattern_player #(
   parameter int unsigned LANES    = 8,
   parameter int unsigned SAMPLE_W = 6,
   parameter int unsigned REG_LEN  = 104,
   localparam int unsigned NUM_REG = LANES * SAMPLE_W,
   localparam int unsigned PH_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                mode_play_req,
   input  logic                load_en,
   input  logic                load_bit,
   input  logic                fast_en,
   output logic [SAMPLE_W-1:0] sample_out
);
   if ((LANES < 2) || ((LANES & (LANES - 1)) != 0)) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if ((SAMPLE_W < 1) || (REG_LEN < 2)) begin : g_bad_size
      $error("SAMPLE_W must be at least 1 and REG_LEN at least 2");
   end

   logic               play_w;
   logic [PH_W-1:0]    phase_w;
   logic               mem_step_w;
   logic               load_step_w;
   logic [NUM_REG-1:0] taps_w;

   tpm_phase_ctrl #(.LANES(LANES)) u_ctrl (
      .clk           (clk),
      .rst           (rst),
      .mode_play_req (mode_play_req),
      .load_en       (load_en),
      .fast_en       (fast_en),
      .play          (play_w),
      .phase         (phase_w),
      .mem_step      (mem_step_w),
      .load_step     (load_step_w)
   );

   tpm_shift_array #(.NUM_REG(NUM_REG), .REG_LEN(REG_LEN)) u_mem (
      .clk       (clk),
      .load_step (load_step_w),
      .mem_step  (mem_step_w),
      .load_bit  (load_bit),
      .taps      (taps_w)
   );

   tpm_lane_mux #(.LANES(LANES), .SAMPLE_W(SAMPLE_W)) u_mux (
      .taps   (taps_w),
      .phase  (phase_w),
      .play   (play_w),
      .sample (sample_out)
   );
endmodule

// File: rtl/tpm_pattern_player_chk.sv
module tpm_pattern_player_chk #(
   parameter int unsigned LANES    = 8,
   parameter int unsigned SAMPLE_W = 6,
   localparam int unsigned PH_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
   input logic                clk,
   input logic                rst,
   input logic                fast_en,
   input logic                mode_play_req,
   input logic [SAMPLE_W-1:0] sample_out,
   input logic                play,
   input logic [PH_W-1:0]     phase
);
   localparam logic [PH_W-1:0] LAST = PH_W'(LANES - 1);

   p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
      !play |-> (sample_out == '0));

   p_phase_step_r4: assert property (@(posedge clk) disable iff (rst)
      (play && fast_en && phase != LAST) |=> (phase == $past(phase) + 1'b1));

   p_phase_wrap_r4: assert property (@(posedge clk) disable iff (rst)
      (play && fast_en && phase == LAST && mode_play_req) |=> (play && phase == '0));

   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (play && !fast_en) |=> ($stable(sample_out) && $stable(phase) && play));

   p_defer_r7: assert property (@(posedge clk) disable iff (rst)
      (play && !(fast_en && phase == LAST)) |=> play);

   p_entry_r8: assert property (@(posedge clk) disable iff (rst)
      (!play && mode_play_req) |=> (play && phase == '0));

   p_load_phase_r9: assert property (@(posedge clk) disable iff (rst)
      !play |-> (phase == '0));
endmodule

bind tpm_pattern_player tpm_pattern_player_chk #(.LANES(LANES), .SAMPLE_W(SAMPLE_W)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .fast_en       (fast_en),
   .mode_play_req (mode_play_req),
   .sample_out    (sample_out),
   .play          (play_w),
   .phase         (phase_w)
);

// File: tb/tb_tpm_pattern_player.sv
`timescale 1ns/1ps
module tb_tpm_pattern_player;
   localparam int LANES = 8;
   localparam int SW    = 6;
   localparam int RL    = 104;
   localparam int NR    = LANES * SW;
   localparam int TOTAL = NR * RL;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          mode_play_req = 1'b0;
   logic          load_en = 1'b0;
   logic          load_bit = 1'b0;
   logic          fast_en = 1'b0;
   logic [SW-1:0] sample_out;

   int n_chk  = 0;
   int n_fail = 0;
   int seed   = 0;
   int em     = 0;
   int ep     = 0;
   bit done   = 1'b0;

   tpm_pattern_player dut (
      .clk(clk), .rst(rst), .mode_play_req(mode_play_req), .load_en(load_en),
      .load_bit(load_bit), .fast_en(fast_en), .sample_out(sample_out)
   );

   always #5 clk = ~clk;

   function automatic logic pat(input int s, input int j);
      int v;
      v = (j * 13 + s) ^ (j >> 2) ^ (j >> 7) ^ (s * j >> 4);
      return v[0];
   endfunction

   function automatic logic [SW-1:0] exp_sample(input int s, input int m, input int p);
      logic [SW-1:0] r;
      for (int b = 0; b < SW; b++)
         r[b] = pat(s, (NR - 1 - (p * SW + b)) * RL + (m % RL));
      return r;
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: sample_out=%h expected %h (m=%0d p=%0d)", req, act, exp, em, ep);
      end
   endtask

   task automatic advance();
      ep = (ep + 1) % LANES;
      if (ep == 0) em++;
   endtask

   task automatic t_reset();
      rst = 1'b1; mode_play_req = 1'b0; load_en = 1'b0; fast_en = 1'b0;
      repeat (3) tick();
      rst = 1'b0;
      for (int i = 0; i < 3; i++) begin
         tick();
         check("R1 reset output zero", sample_out, '0);
      end
   endtask

   task automatic t_load(input int s);
      seed = s;
      load_en = 1'b1;
      for (int j = 0; j < TOTAL; j++) begin
         load_bit = pat(s, j);
         tick();
         if (j == 100 || j == TOTAL - 1)
            check("R10 zero while loading", sample_out, '0);
      end
      load_en = 1'b0;
   endtask

   task automatic t_enter_play(input string req);
      mode_play_req = 1'b1;
      tick();
      ep = 0;
      check(req, sample_out, exp_sample(seed, em, ep));
   endtask

   task automatic t_play(input int n, input string req);
      fast_en = 1'b1;
      for (int i = 0; i < n; i++) begin
         tick();
         advance();
         check(req, sample_out, exp_sample(seed, em, ep));
      end
   endtask

   task automatic t_hold();
      fast_en = 1'b0;
      for (int i = 0; i < 5; i++) begin
         tick();
         check("R6 hold without fast_en", sample_out, exp_sample(seed, em, ep));
      end
   endtask

   task automatic t_load_in_play();
      fast_en = 1'b1;
      load_en = 1'b1;
      for (int i = 0; i < 20; i++) begin
         load_bit = i[0];
         tick();
         advance();
         check("R9 load_en ignored in playback", sample_out, exp_sample(seed, em, ep));
      end
      load_en = 1'b0;
   endtask

   task automatic t_defer_switch();
      fast_en = 1'b1;
      while (ep != 2) begin
         tick();
         advance();
      end
      mode_play_req = 1'b0;
      while (ep != LANES - 1) begin
         tick();
         advance();
         check("R7 still playing after request drop", sample_out, exp_sample(seed, em, ep));
      end
      tick();
      advance();
      check("R7 load mode after wrap edge", sample_out, '0);
      for (int i = 0; i < 20; i++) begin
         tick();
         check("R9 fast_en ignored in load mode", sample_out, '0);
      end
      fast_en = 1'b0;
      t_enter_play("R8 resume at next memory cycle");
   endtask

   initial begin
      t_reset();
      t_load(1);
      em = 0;
      t_enter_play("R2 first sample of loaded pattern");
      t_play(LANES * RL * 2 + 5, "R3 R4 R5 lane order and repeat");
      t_hold();
      t_load_in_play();
      t_defer_switch();
      t_play(LANES * 3, "R8 continued playback");
      t_reset();
      t_load(7);
      em = 0;
      t_enter_play("R2 second pattern first sample");
      t_play(LANES * RL + 3, "R3 second pattern");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run incomplete, actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule